// File: doc/BRIEF.md
# Grouped Sensor Readout Sequencer

This controller runs the readout phase that ends each error-correction cycle, in which only the surface-code ancilla qubits are measured. The sensor dots sit in several readout modules, and every module has one shared measurement line. A single group address is broadcast to a global demultiplexer that all modules share, so every module steps through the same groups at the same time. At each step one group of sensors, `GRP_SZ` wide, is pulsed into its sensitive state. Every other sensor stays blocked at high impedance.

For each group the sequencer first holds the plunger pulse for a programmable dwell. It then opens a sample window and waits for each module's front end to return a valid flag together with a group-wide result word, one bit per sensor slot. Each result is written into an internal buffer entry addressed by (module, group), where bit s of the stored word is slot s. If a module is still silent when the timeout expires, its entry is marked as an error and the sequencer moves on. Total readout time grows with the number of groups, not with the number of qubits. After the last group, a one-cycle done pulse is raised.

Top module: `rdo_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `plunger_pulse` and `cycle_done` are 0, `grp_addr` is 0, and every buffer entry reads word 0 with error flag 0.
- R2: A `start` pulse while idle begins a pass at group 0. A `start` seen while busy has no effect: the group sequence and its timing continue unchanged.
- R3: Groups are visited in the order 0, 1, …, `N_GRP-1`, and `grp_addr` holds the current index for the whole step. Each step is a dwell of max(`dwell_cfg`,1) cycles followed by a sample window. `plunger_pulse` and `busy` are 1 throughout every step and 0 when idle.
- R4: In the sample window, the first cycle in which `res_valid[m]` is 1 stores `res_word[m*GRP_SZ +: GRP_SZ]` into entry (m, current group) with error flag 0. Later valids from that module in the same window are ignored, and so are valids during the dwell.
- R5: The window closes in the cycle where every module has reported, or in the cycle where its timer reaches `timeout_cfg`. This means the window lasts at most `timeout_cfg+1` cycles. Modules still silent at the close get word 0 with error flag 1.
- R6: `cycle_done` is a single-cycle pulse in the cycle after the last group's window closes, and `busy` falls in that same cycle.
- R7: `rd_word`/`rd_err` show entry (`rd_mod`, `rd_grp`) combinationally. An entry keeps its value until the same (module, group) is written in a later pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a readout pass (idle only) |
| dwell_cfg | input | DW | Plunger dwell length in cycles (0 treated as 1) |
| timeout_cfg | input | TW | Sample-window timer limit |
| res_valid | input | N_MOD | Per-module result strobe |
| res_word | input | N_MOD*GRP_SZ | Per-module group result, module m at bits m*GRP_SZ |
| grp_addr | output | GW | Group address to the shared demultiplexer |
| plunger_pulse | output | 1 | Pulses the selected group's plungers |
| busy | output | 1 | A pass is in progress |
| cycle_done | output | 1 | One-cycle pulse after the final group |
| rd_mod | input | MW | Buffer read module index |
| rd_grp | input | GW | Buffer read group index |
| rd_word | output | GRP_SZ | Stored per-slot outcomes |
| rd_err | output | 1 | Stored timeout flag |

## Verification
The hardest situation to reach is a window in which some modules have already reported, another module sends a second valid, and one module stays silent until the timer ends the window. Also hard to hit are windows that close on their very first cycle, and a close that lands on the final group. The stimulus gets there by giving each module random valid pulses in every cycle, including during the dwell, while some modules are masked as permanently silent. Passes are also run with a zero timeout and a zero dwell, and with valids either always high or always low. A behavioural model tracks the expected pending set and buffer contents every cycle.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DWELL  = 2'd1,
    PH_SAMPLE = 2'd2
  } rdo_phase_e;

  // Flat buffer position of the entry for (module, group).
  function automatic int entry_index(input int mod_i, input int grp_i, input int n_grp);
    return mod_i * n_grp + grp_i;
  endfunction

  // Bit offset of module m's result word inside the packed front-end bus.
  function automatic int word_base(input int mod_i, input int grp_sz);
    return mod_i * grp_sz;
  endfunction

endpackage

// File: rtl/rdo_step_ctrl.sv
module rdo_step_ctrl
  import rdo_pkg::*;
#(
  parameter int N_GRP = 6,
  parameter int GW    = 3,
  parameter int DW    = 8,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dwell_cfg,
  input  logic [TW-1:0] timeout_cfg,
  input  logic          all_in,
  output rdo_phase_e    phase,
  output logic [GW-1:0] grp,
  output logic          arm,
  output logic          sampling,
  output logic          close,
  output logic          cycle_done
);

  localparam logic [GW-1:0] LAST_GRP = GW'(N_GRP - 1);

  rdo_phase_e    phase_q;
  logic [GW-1:0] grp_q;
  logic [DW-1:0] dcnt_q;
  logic [TW-1:0] tcnt_q;
  logic          done_q;
  logic [DW-1:0] dwell_eff;
  logic          timeout_hit;
  logic          last_grp;

  assign dwell_eff   = (dwell_cfg == '0) ? DW'(1) : dwell_cfg;
  assign sampling    = (phase_q == PH_SAMPLE);
  assign arm         = (phase_q == PH_DWELL) && (dcnt_q >= dwell_eff);
  assign timeout_hit = (tcnt_q >= timeout_cfg);
  assign close       = sampling && (all_in || timeout_hit);
  assign last_grp    = (grp_q == LAST_GRP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      grp_q   <= '0;
      dcnt_q  <= '0;
      tcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= close && last_grp;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_DWELL;
            grp_q   <= '0;
            dcnt_q  <= DW'(1);
          end
        end
        PH_DWELL: begin
          if (arm) begin
            phase_q <= PH_SAMPLE;
            tcnt_q  <= '0;
          end else begin
            dcnt_q <= dcnt_q + DW'(1);
          end
        end
        PH_SAMPLE: begin
          if (close) begin
            if (last_grp) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_DWELL;
              grp_q   <= grp_q + GW'(1);
              dcnt_q  <= DW'(1);
            end
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign grp        = grp_q;
  assign cycle_done = done_q;

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) && start && !close |=> grp_q == $past(grp_q));

  // R3
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampling && !close |=> $stable(grp_q));

  // R6
  done_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(grp_q) == LAST_GRP);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/rdo_capture.sv
module rdo_capture #(
  parameter int N_MOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             sampling,
  input  logic             close,
  input  logic [N_MOD-1:0] res_valid,
  output logic             all_in,
  output logic [N_MOD-1:0] wr_ok,
  output logic [N_MOD-1:0] wr_err
);

  logic [N_MOD-1:0] pend_q;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[m] <= 1'b0;
      end else if (arm) begin
        pend_q[m] <= 1'b1;
      end else if (close) begin
        pend_q[m] <= 1'b0;
      end else if (sampling && res_valid[m]) begin
        pend_q[m] <= 1'b0;
      end
    end
    assign wr_ok[m]  = sampling && pend_q[m] && res_valid[m];
    assign wr_err[m] = close && pend_q[m] && !res_valid[m];
  end

  assign all_in = ((pend_q & ~res_valid) == '0);

  // R4
  pend_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((pend_q & ~$past(pend_q)) == '0));

  // R5
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok & wr_err) == '0);

  // R5
  close_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> pend_q == '0);

endmodule

// File: rtl/rdo_result_buf.sv
module rdo_result_buf
  import rdo_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int N_GRP  = 6,
  parameter int GRP_SZ = 8,
  parameter int GW     = 3,
  parameter int MW     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GW-1:0]           grp,
  input  logic [N_MOD-1:0]        wr_ok,
  input  logic [N_MOD-1:0]        wr_err,
  input  logic [N_MOD*GRP_SZ-1:0] res_word,
  input  logic [MW-1:0]           rd_mod,
  input  logic [GW-1:0]           rd_grp,
  output logic [GRP_SZ-1:0]       rd_word,
  output logic                    rd_err
);

  localparam int N_ENT = N_MOD * N_GRP;

  logic [N_ENT*GRP_SZ-1:0] words_flat;
  logic [N_ENT-1:0]        errs_flat;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      localparam int IDX = entry_index(m, g, N_GRP);
      logic [GRP_SZ-1:0] word_q;
      logic              err_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q <= '0;
          err_q  <= 1'b0;
        end else if (grp == GW'(g)) begin
          if (wr_ok[m]) begin
            word_q <= res_word[word_base(m, GRP_SZ) +: GRP_SZ];
            err_q  <= 1'b0;
          end else if (wr_err[m]) begin
            word_q <= '0;
            err_q  <= 1'b1;
          end
        end
      end
      assign words_flat[IDX*GRP_SZ +: GRP_SZ] = word_q;
      assign errs_flat[IDX]                   = err_q;
    end
  end

  logic rd_in_range;
  int   rd_idx;

  assign rd_in_range = ({1'b0, rd_mod} < (MW+1)'(N_MOD)) &&
                       ({1'b0, rd_grp} < (GW+1)'(N_GRP));
  assign rd_idx      = entry_index(int'(rd_mod), int'(rd_grp), N_GRP);

  always_comb begin
    rd_word = '0;
    rd_err  = 1'b0;
    if (rd_in_range) begin
      rd_word = words_flat[rd_idx*GRP_SZ +: GRP_SZ];
      rd_err  = errs_flat[rd_idx];
    end
  end

  // R7
  rd_zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_word == '0);

endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
  import rdo_pkg::*;
#(
  parameter int N_MOD  = 4,
  parameter int N_GRP  = 6,
  parameter int GRP_SZ = 8,
  parameter int DW     = 8,
  parameter int TW     = 8,
  parameter int GW     = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  parameter int MW     = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DW-1:0]           dwell_cfg,
  input  logic [TW-1:0]           timeout_cfg,
  input  logic [N_MOD-1:0]        res_valid,
  input  logic [N_MOD*GRP_SZ-1:0] res_word,
  output logic [GW-1:0]           grp_addr,
  output logic                    plunger_pulse,
  output logic                    busy,
  output logic                    cycle_done,
  input  logic [MW-1:0]           rd_mod,
  input  logic [GW-1:0]           rd_grp,
  output logic [GRP_SZ-1:0]       rd_word,
  output logic                    rd_err
);

  rdo_phase_e       phase;
  logic [GW-1:0]    grp;
  logic             arm;
  logic             sampling;
  logic             close;
  logic             all_in;
  logic [N_MOD-1:0] wr_ok;
  logic [N_MOD-1:0] wr_err;

  rdo_step_ctrl #(
    .N_GRP(N_GRP), .GW(GW), .DW(DW), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dwell_cfg(dwell_cfg), .timeout_cfg(timeout_cfg), .all_in(all_in),
    .phase(phase), .grp(grp), .arm(arm), .sampling(sampling),
    .close(close), .cycle_done(cycle_done)
  );

  rdo_capture #(
    .N_MOD(N_MOD)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sampling(sampling),
    .close(close), .res_valid(res_valid), .all_in(all_in),
    .wr_ok(wr_ok), .wr_err(wr_err)
  );

  rdo_result_buf #(
    .N_MOD(N_MOD), .N_GRP(N_GRP), .GRP_SZ(GRP_SZ), .GW(GW), .MW(MW)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .grp(grp), .wr_ok(wr_ok), .wr_err(wr_err),
    .res_word(res_word), .rd_mod(rd_mod), .rd_grp(rd_grp),
    .rd_word(rd_word), .rd_err(rd_err)
  );

  assign grp_addr      = grp;
  assign busy          = (phase != PH_IDLE);
  assign plunger_pulse = (phase == PH_DWELL) || (phase == PH_SAMPLE);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !plunger_pulse);

endmodule

// File: tb/rdo_seq_tb.sv
`timescale 1ns/1ps
module rdo_seq_tb;
  localparam int NM = 4;
  localparam int NG = 6;
  localparam int GS = 8;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int GW = 3;
  localparam int MW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DW-1:0]     dwell_cfg = '0;
  logic [TW-1:0]     timeout_cfg = '0;
  logic [NM-1:0]     res_valid = '0;
  logic [NM*GS-1:0]  res_word = '0;
  logic [GW-1:0]     grp_addr;
  logic              plunger_pulse, busy, cycle_done;
  logic [MW-1:0]     rd_mod = '0;
  logic [GW-1:0]     rd_grp = '0;
  logic [GS-1:0]     rd_word;
  logic              rd_err;

  rdo_seq #(.N_MOD(NM), .N_GRP(NG), .GRP_SZ(GS), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dwell_cfg(dwell_cfg),
    .timeout_cfg(timeout_cfg), .res_valid(res_valid), .res_word(res_word),
    .grp_addr(grp_addr), .plunger_pulse(plunger_pulse), .busy(busy),
    .cycle_done(cycle_done), .rd_mod(rd_mod), .rd_grp(rd_grp),
    .rd_word(rd_word), .rd_err(rd_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Behavioural reference: 0 idle, 1 dwell, 2 sampling.
  int m_stage = 0;
  int m_group = 0;
  int m_left  = 0;
  int m_timer = 0;
  bit m_done  = 0;
  bit m_wait [NM];
  int m_word [NM][NG];
  bit m_err  [NM][NG];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_group = 0; m_done = 0;
      for (int m = 0; m < NM; m++) begin
        m_wait[m] = 0;
        for (int g = 0; g < NG; g++) begin m_word[m][g] = 0; m_err[m][g] = 0; end
      end
    end else begin
      m_done = 0;
      if (m_stage == 0) begin
        if (start) begin
          m_stage = 1; m_group = 0;
          m_left = (dwell_cfg == 0) ? 1 : int'(dwell_cfg);
        end
      end else if (m_stage == 1) begin
        m_left--;
        if (m_left == 0) begin
          m_stage = 2; m_timer = 0;
          for (int m = 0; m < NM; m++) m_wait[m] = 1;
        end
      end else begin
        int waiting;
        waiting = 0;
        for (int m = 0; m < NM; m++) begin
          if (m_wait[m] && res_valid[m]) begin
            m_word[m][m_group] = int'(res_word[m*GS +: GS]);
            m_err[m][m_group]  = 0;
            m_wait[m] = 0;
          end
          if (m_wait[m]) waiting++;
        end
        if (waiting == 0 || m_timer >= int'(timeout_cfg)) begin
          for (int m = 0; m < NM; m++) begin
            if (m_wait[m]) begin m_word[m][m_group] = 0; m_err[m][m_group] = 1; end
            m_wait[m] = 0;
          end
          if (m_group == NG - 1) begin
            m_stage = 0; m_done = 1;
          end else begin
            m_group++; m_stage = 1;
            m_left = (dwell_cfg == 0) ? 1 : int'(dwell_cfg);
          end
        end else begin
          m_timer++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Stimulus controls
  int  vprob = 0;
  bit [NM-1:0] silent = '0;
  bit  start_req = 0;
  bit  rd_fixed = 0;
  int  rd_m_fix = 0, rd_g_fix = 0;
  bit  saw_done = 0;

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      check(grp_addr == GW'(m_group), "R2 R3", "grp_addr", int'(grp_addr), m_group);
      check(plunger_pulse == (m_stage != 0), "R3", "plunger_pulse", int'(plunger_pulse), int'(m_stage != 0));
      check(busy == (m_stage != 0), "R3 R6", "busy", int'(busy), int'(m_stage != 0));
      check(cycle_done == m_done, "R6", "cycle_done", int'(cycle_done), int'(m_done));
      check(int'(rd_word) == m_word[rd_mod][rd_grp], "R4 R5 R7", "rd_word", int'(rd_word), m_word[rd_mod][rd_grp]);
      check(rd_err == m_err[rd_mod][rd_grp], "R4 R5 R7", "rd_err", int'(rd_err), int'(m_err[rd_mod][rd_grp]));
    end
    if (cycle_done) saw_done = 1;
    start = start_req;
    start_req = 0;
    for (int m = 0; m < NM; m++) begin
      res_valid[m] = !silent[m] && (($urandom % 100) < vprob);
      res_word[m*GS +: GS] = GS'($urandom);
    end
    if (rd_fixed) begin
      rd_mod = MW'(rd_m_fix); rd_grp = GW'(rd_g_fix);
    end else begin
      rd_mod = MW'($urandom % NM); rd_grp = GW'($urandom % NG);
    end
  endtask

  task automatic sweep(input string req);
    rd_fixed = 1;
    for (int m = 0; m < NM; m++)
      for (int g = 0; g < NG; g++) begin
        rd_m_fix = m; rd_g_fix = g;
        tick();
      end
    tick();
    rd_fixed = 0;
    check(!busy, req, "idle after sweep", int'(busy), 0);
  endtask

  task automatic run_pass(input int dwell, input int tmo, input int prob,
                          input bit [NM-1:0] dead, input bit poke);
    dwell_cfg = DW'(dwell); timeout_cfg = TW'(tmo); vprob = prob; silent = dead;
    saw_done = 0;
    start_req = 1;
    tick();
    for (int i = 0; i < 3000 && !saw_done; i++) begin
      if (poke && (i % 7 == 3)) start_req = 1;  // R2: must be ignored while busy
      tick();
    end
    check(saw_done, "R6", "pass completed", int'(saw_done), 1);
    vprob = 0;
    tick(); tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state observed at the ports
    check(!busy && !plunger_pulse && !cycle_done, "R1", "idle outputs", int'(busy), 0);
    check(grp_addr == '0, "R1", "grp_addr reset", int'(grp_addr), 0);
    rst_n = 1'b1;
    tick();
    sweep("R1");
    run_pass(3, 6, 30, '0, 0);
    sweep("R4");
    run_pass(0, 0, 100, '0, 0);
    sweep("R5");
    run_pass(2, 4, 40, 4'b0010, 1);
    sweep("R2");
    run_pass(1, 0, 0, '0, 0);
    sweep("R5");
    run_pass(4, 10, 15, 4'b1000, 1);
    run_pass(5, 3, 60, '0, 0);
    sweep("R7");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule